// File: doc/BRIEF.md
# Prescaled Up-Counting Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit counter climbs by one on each tick of a prescaler, and the prescaler divides the system clock by one of eight fixed divisors. Software loads the counter with 65536 minus the number of ticks it wants to allow. It then refreshes the counter before the count passes 0xFFFF. If the count wraps to zero, the block sets a sticky expiry flag and drives a reset-request pulse to an external reset controller. That controller does not drive this block's reset, so the flag can be read after the system restarts and the cause of the restart identified.

Registers sit on a simple synchronous bus. Writes are taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

- Address 0 is the control/status byte.
- Address 1 is a second control byte that accepts writes and ignores them.
- Address 2 is the counter.
- Address 3 reads zero.

A busy bit tells software that a recent write is still inside its synchronization window. Software should wait for it to clear before enabling the timer.

Top module: `upcount_wdog`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), address 0 reads 0x0000, address 2 reads 0x0000 and `rst_req` is low.
- R2: The divisor code in bits 2:0 of address 0 selects, in code order 0 to 7, a divisor of 1, 4, 16, 32, 64, 128, 1024 or 4096. The write that sets the enable bit restarts the prescaler. While enabled, the counter first increments exactly one divisor period of clocks after that write's edge, and then once per divisor period.
- R3: The counter advances only while the enable bit (bit 7 of address 0) is 1. After a write clears that bit, the value in address 2 holds.
- R4: A write to address 2 loads bits 15:0 into the counter at that edge, whether or not the timer is running. The load takes precedence over a tick in the same cycle. A read of address 2 returns the current count.
- R5: Bit 5 of address 0 is read-only. It becomes 1 after any write to address 0 or address 2, and returns to 0 after 2 further prescaler ticks. A write to address 1 does not set it.
- R6: When the count wraps from 0xFFFF to 0x0000, bit 4 of address 0 becomes 1 and `rst_req` is high for exactly 4 consecutive clocks, both starting at that edge.
- R7: Bit 4 of address 0 stays at 1 until software writes address 0 with bit 4 equal to 0, or until reset. Writing a 1 to bit 4 leaves it unchanged.
- R8: A write of any value to address 1 changes no state. Address 1 and address 3 always read 0x0000.
- R9: With the counter loaded to 0xFFFF and divisor code 0, writing 0x80 to address 0 raises `rst_req` at the second clock edge, counting the edge that captures the write as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register address (0 control, 1 second control, 2 counter) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Reset request, high for 4 clocks after expiry |

## Verification
Register writes take effect at the edge that captures them, so loaded counts, control bits and the busy bit are read back on the falling edge right after the write. The first count step after enabling is due exactly one divisor period of clocks after the enabling edge. The bench samples one clock before that edge and again at it, for every divisor code. Expiry with code 0 is due one edge after the enabling edge, and the bench then counts exactly four high cycles of `rst_req`. A behavioural model steps alongside the design and is compared a quarter period after every rising edge, when inputs are stable and outputs have settled.

// File: rtl/wdog_pkg.sv
// Package: shared constants, register addresses and the divisor decode
// for the prescaled up-counting watchdog.
// Assumes the prescaler counter is wide enough for the largest divisor.
package wdog_pkg;
    localparam int SEL_W       = 3;
    localparam int PRE_W       = 12;
    localparam int ADDR_W      = 2;
    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_BSY_BIT = 5;
    localparam int CTL_OVF_BIT = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTL  = 2'd0,
        ADR_AUX  = 2'd1,
        ADR_CNT  = 2'd2,
        ADR_NONE = 2'd3
    } wd_addr_e;

    // Terminal prescaler count (divisor minus one) for each select code.
    function automatic logic [PRE_W-1:0] div_last(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    div_last = PRE_W'(0);
            3'd1:    div_last = PRE_W'(3);
            3'd2:    div_last = PRE_W'(15);
            3'd3:    div_last = PRE_W'(31);
            3'd4:    div_last = PRE_W'(63);
            3'd5:    div_last = PRE_W'(127);
            3'd6:    div_last = PRE_W'(1023);
            default: div_last = PRE_W'(4095);
        endcase
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Divides the system clock by the divisor that the select code picks and
// emits a one-cycle tick at the end of each period.
// Assumes: the prescaler runs freely so that the busy window can time out
// while the timer is stopped. A restart pulse forces the count back to
// zero, so the next tick comes one full period later. Lowering the divisor
// while running ends the current period at once.
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    // Terminal count decode and tick generation.
    always_comb begin
        last = div_last(sel);
        tick = (pre_q >= last);
    end

    // Period counter: clears on restart or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (restart || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R2: a restart is never followed by a tick unless the divisor is 1.
    p_restart_full_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && sel != 3'd0) |=> !tick || (sel == 3'd0));
endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Holds the watchdog count. It loads on a bus write, advances on enabled
// ticks and flags a wrap from all ones to zero. It also stretches the wrap
// into a reset-request pulse of fixed length.
// Assumes: a load and a tick in the same cycle resolve to the load, and a
// load suppresses the wrap.
module wdog_counter #(
    parameter int CNT_W        = 16,
    parameter int PULSE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt,
    output logic             rst_req
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pulse_q;

    // Wrap detection: an enabled tick at all ones with no load pending.
    assign wrap_evt = en && tick && !ld && (cnt_q == {CNT_W{1'b1}});
    assign cnt      = cnt_q;
    assign rst_req  = (pulse_q != '0);

    // Count register: load wins over advance; wrap comes from modular add.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (en && tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Reset-request stretcher: reloads on every wrap, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (wrap_evt)
            pulse_q <= PW'(PULSE_CYCLES);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
    end

    // Checker state: length of the current run of rst_req high.
    int hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= 0;
        else if (rst_req)
            hi_run <= hi_run + 1;
        else
            hi_run <= 0;
    end

    // R3: with the timer stopped and no load, the count holds.
    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> $stable(cnt_q));
    // R4: a load is visible on the next cycle.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(ld_val)));
    // R2: without a load the count moves by at most one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
    // R6: a wrap lands at zero with the request raised.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (rst_req && cnt_q == '0));
    // R6: the request never lasts longer than the pulse length.
    p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= PULSE_CYCLES);
endmodule

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Register file. It decodes bus writes into control fields, the sticky
// expiry flag, the busy window and the counter load, and it muxes read data.
// Assumes: the second control byte has no storage, and the busy window
// counts prescaler ticks rather than system clocks.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int BUSY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              tick,
    input  logic              wrap_evt,
    input  logic [CNT_W-1:0]  cnt,
    output logic              en,
    output logic [SEL_W-1:0]  sel,
    output logic              restart,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val,
    output logic              ovf,
    output logic              busy,
    output logic [CNT_W-1:0]  bus_rdata
);
    localparam int BW = $clog2(BUSY_TICKS + 1);

    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             ovf_q;
    logic [BW-1:0]    busy_q;
    logic             wr_ctl;
    logic             wr_cnt;
    logic             wr_aux;

    // Write decode and enable-rise detection.
    always_comb begin
        wr_ctl  = bus_wr && (bus_addr == ADR_CTL);
        wr_cnt  = bus_wr && (bus_addr == ADR_CNT);
        wr_aux  = bus_wr && (bus_addr == ADR_AUX);
        restart = wr_ctl && bus_wdata[CTL_EN_BIT] && !en_q;
    end

    assign en         = en_q;
    assign sel        = sel_q;
    assign ovf        = ovf_q;
    assign busy       = (busy_q != '0);
    assign cnt_ld     = wr_cnt;
    assign cnt_ld_val = bus_wdata;

    // Control fields: enable and divisor select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_ctl) begin
            en_q  <= bus_wdata[CTL_EN_BIT];
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    // Sticky expiry flag: set by a wrap, cleared only by writing a zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (wrap_evt)
            ovf_q <= 1'b1;
        else if (wr_ctl && !bus_wdata[CTL_OVF_BIT])
            ovf_q <= 1'b0;
    end

    // Busy window: reload on a control or counter write, drain on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= '0;
        else if (wr_ctl || wr_cnt)
            busy_q <= BW'(BUSY_TICKS);
        else if (tick && busy_q != '0)
            busy_q <= busy_q - 1'b1;
    end

    // Read mux: the control byte is zero-extended; unused addresses read 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTL: begin
                bus_rdata[CTL_EN_BIT]  = en_q;
                bus_rdata[CTL_BSY_BIT] = busy;
                bus_rdata[CTL_OVF_BIT] = ovf_q;
                bus_rdata[SEL_W-1:0]   = sel_q;
            end
            ADR_CNT: bus_rdata = cnt;
            default: bus_rdata = '0;
        endcase
    end

    // R5: a control or counter write always opens the busy window.
    p_busy_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl || wr_cnt) |=> busy);
    // R5: a write to the second control byte alone never opens it.
    p_aux_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_aux && !busy) |=> !busy);
    // R6: a wrap sets the expiry flag.
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> ovf_q);
    // R7: the flag survives anything but an explicit zero write.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_ctl && !bus_wdata[CTL_OVF_BIT])) |=> ovf_q);
endmodule

// File: rtl/upcount_wdog.sv
// Module: upcount_wdog (top)
// Prescaled up-counting watchdog. It ties the prescaler, the counter with
// its reset-request stretcher, and the register file together.
// Assumes: rst_n is a power-on reset that the reset request does not feed
// back into, so the expiry flag survives a system restart.
module upcount_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PULSE_CYCLES = 4,
    parameter int BUSY_TICKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              rst_req
);
    logic             tick;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             restart;
    logic             cnt_ld;
    logic [CNT_W-1:0] cnt_ld_val;
    logic [CNT_W-1:0] cnt;
    logic             wrap_evt;
    logic             ovf;
    logic             busy;

    wdog_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (sel),
        .tick    (tick)
    );

    wdog_counter #(
        .CNT_W        (CNT_W),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .ld       (cnt_ld),
        .ld_val   (cnt_ld_val),
        .cnt      (cnt),
        .wrap_evt (wrap_evt),
        .rst_req  (rst_req)
    );

    wdog_regs #(
        .CNT_W      (CNT_W),
        .BUSY_TICKS (BUSY_TICKS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .tick       (tick),
        .wrap_evt   (wrap_evt),
        .cnt        (cnt),
        .en         (en),
        .sel        (sel),
        .restart    (restart),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .ovf        (ovf),
        .busy       (busy),
        .bus_rdata  (bus_rdata)
    );

    // R8: a write to the second control byte leaves the control fields alone.
    p_aux_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_AUX) |=> ($stable(en) && $stable(sel) && $stable(ovf)));
    // R9/R6: the expiry flag and the request rise together.
    p_flag_with_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ovf);
endmodule

// File: tb/upcount_wdog_tb.sv
// Bench for upcount_wdog. A behavioural model steps on every rising edge
// and is compared a quarter period later. Directed sequences drive the
// bus on falling edges and check named requirements.
module upcount_wdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    upcount_wdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_en = 0, m_sel = 0, m_pre = 0, m_cnt = 0, m_busy = 0, m_ovf = 0, m_pulse = 0;

    function automatic int mdiv(input int code);
        case (code)
            0: return 1;    1: return 4;    2: return 16;   3: return 32;
            4: return 64;   5: return 128;  6: return 1024; default: return 4096;
        endcase
    endfunction

    function automatic int m_read(input int a);
        if (a == 0) return (m_en << 7) | ((m_busy > 0) << 5) | (m_ovf << 4) | m_sel;
        if (a == 2) return m_cnt;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_sel = 0; m_pre = 0; m_cnt = 0; m_busy = 0; m_ovf = 0; m_pulse = 0;
        end else begin
            bit wa, wc, tk, st, wrp;
            wa  = bus_wr && bus_addr == 2'd0;
            wc  = bus_wr && bus_addr == 2'd2;
            tk  = (m_pre >= mdiv(m_sel) - 1);
            st  = wa && bus_wdata[7] && (m_en == 0);
            wrp = 1'b0;
            m_pre = (st || tk) ? 0 : m_pre + 1;
            if (wc) m_cnt = int'(bus_wdata);
            else if (m_en != 0 && tk) begin
                if (m_cnt == 65535) begin m_cnt = 0; wrp = 1'b1; end
                else m_cnt = m_cnt + 1;
            end
            if (wa || wc) m_busy = 2;
            else if (tk && m_busy > 0) m_busy = m_busy - 1;
            if (wrp) m_pulse = 4;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (wrp) m_ovf = 1;
            else if (wa && !bus_wdata[4]) m_ovf = 0;
            if (wa) begin m_en = int'(bus_wdata[7]); m_sel = int'(bus_wdata[2:0]); end
        end
    end

    // Per-cycle comparison against the model.
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            checks++;
            if (rst_req !== (m_pulse > 0)) begin
                errors++;
                $display("FAIL R6 model rst_req actual=%0b expected=%0b", rst_req, m_pulse > 0);
            end
            checks++;
            if (int'(bus_rdata) != m_read(int'(bus_addr))) begin
                errors++;
                $display("FAIL %s model rdata addr=%0d actual=%h expected=%h",
                         (bus_addr == 2'd0) ? "R5" : "R2", bus_addr, bus_rdata, m_read(int'(bus_addr)));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(2'd0, v);
            if (((v >> 5) & 1) == 0) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
            finish_run();
        end
    end

    // ---------------- directed sequences ----------------
    initial begin
        int v, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(2'd0, v); chk("R1 ctl", v, 0);
        bus_read(2'd2, v); chk("R1 cnt", v, 0);
        chk("R1 rst_req", int'(rst_req), 0);

        // R8: second control byte ignored, reads zero
        bus_write(2'd1, 16'h00FF);
        bus_read(2'd0, v); chk("R8 ctl unchanged, no busy", v, 0);
        bus_read(2'd1, v); chk("R8 aux reads 0", v, 0);
        bus_read(2'd3, v); chk("R8 spare reads 0", v, 0);

        // R4 + R5: load while stopped, busy window of two ticks (code 0)
        bus_write(2'd2, 16'h1234);
        bus_read(2'd2, v); chk("R4 load", v, 16'h1234);
        bus_read(2'd0, v); chk("R5 busy set", (v >> 5) & 1, 1);
        @(negedge clk);
        bus_read(2'd0, v); chk("R5 busy after 1 tick", (v >> 5) & 1, 1);
        @(negedge clk);
        bus_read(2'd0, v); chk("R5 busy cleared", (v >> 5) & 1, 0);

        // R3: stopped counter holds
        repeat (20) @(negedge clk);
        bus_read(2'd2, v); chk("R3 hold while off", v, 16'h1234);

        // R2: every divisor code, first step exactly one period after enable
        for (int code = 0; code < 8; code++) begin
            int d;
            d = mdiv(code);
            bus_write(2'd0, 16'(code));
            bus_write(2'd2, 16'h0100);
            bus_write(2'd0, 16'(16'h0080 | code));
            repeat (d - 1) @(negedge clk);
            bus_read(2'd2, v); chk($sformatf("R2 code %0d before period", code), v, 16'h0100);
            @(negedge clk);
            bus_read(2'd2, v); chk($sformatf("R2 code %0d first step", code), v, 16'h0101);
            if (code < 6) begin
                repeat (d) @(negedge clk);
                bus_read(2'd2, v); chk($sformatf("R2 code %0d second step", code), v, 16'h0102);
            end
        end

        // R4: keepalive reload while running (code 0) wins over the tick
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'h0080);
        repeat (5) @(negedge clk);
        bus_write(2'd2, 16'h5000);
        bus_read(2'd2, v); chk("R4 keepalive load", v, 16'h5000);
        @(negedge clk);
        bus_read(2'd2, v); chk("R4 counts on after load", v, 16'h5001);

        // R3: clearing enable freezes the count
        bus_write(2'd0, 16'h0000);
        bus_read(2'd2, hi);
        repeat (10) @(negedge clk);
        bus_read(2'd2, v); chk("R3 frozen after disable", v, hi);

        // R9 + R6: fast expiry and pulse length
        bus_write(2'd2, 16'hFFFF);
        wait_idle();
        bus_write(2'd0, 16'h0080);
        chk("R9 no request at enable edge", int'(rst_req), 0);
        @(negedge clk);
        chk("R9 request at second edge", int'(rst_req), 1);
        bus_read(2'd0, v); chk("R6 flag set", (v >> 4) & 1, 1);
        bus_read(2'd2, v); chk("R6 count wrapped to 0", v, 0);
        hi = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rst_req) hi++;
        end
        chk("R6 pulse length", hi, 4);

        // R7: flag sticky against writing 1, cleared by writing 0
        bus_write(2'd0, 16'h0010);
        bus_read(2'd0, v); chk("R7 flag kept on write 1", (v >> 4) & 1, 1);
        repeat (5) @(negedge clk);
        bus_read(2'd0, v); chk("R7 flag still set", (v >> 4) & 1, 1);
        bus_write(2'd0, 16'h0000);
        bus_read(2'd0, v); chk("R7 flag cleared by 0", (v >> 4) & 1, 0);

        // R7 + R1: reset clears the flag
        bus_write(2'd2, 16'hFFFF);
        bus_write(2'd0, 16'h0080);
        repeat (8) @(negedge clk);
        bus_read(2'd0, v); chk("R7 flag set again", (v >> 4) & 1, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(2'd0, v); chk("R7 reset clears flag", v, 0);
        chk("R1 rst_req after reset", int'(rst_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule